// File: doc/BRIEF.md
# Memory-Card Command Engine

This block is the command half of a memory-card host controller. Software programs a 32-bit argument through two 16-bit halves. It then writes a command word. The engine holds that command on a valid/ready request channel toward the card side. Once the request is accepted, the engine waits for a 128-bit response beat on a second valid/ready channel, or gives up after a programmable number of cycles.

An accepted response is split into eight 16-bit response registers. The engine then updates a sticky status word: completion, no-response/timeout, card-reported error and operating-conditions busy. An interrupt line is raised whenever a status bit is set whose enable bit is also set.

Back-pressure rules:
- The request channel keeps `cmd_valid` high with a stable payload until `cmd_ready` is seen.
- The response channel raises `rsp_ready` only while a response is awaited.
- A beat transfers on the cycle where `rsp_valid` and `rsp_ready` are both high.

The register bus is a plain synchronous write port with a combinational read mux. Byte offsets are:

| Offset | Register |
|---|---|
| 0x00 | Command word |
| 0x04 | Argument, low half |
| 0x08 | Argument, high half |
| 0x10 | Status |
| 0x14 | Interrupt enable |
| 0x18 | Timeout |
| 0x34 | Option (bit 13 only) |
| 0x40 + 4i | Response register i |

Any other offset reads zero.

Top module: `card_cmd_engine`

## Requirements
- R1: The command word holds the index in bits 5:0, response type in bits 10:8, command kind in bits 13:12 and direction in bit 15. These are presented on `cmd_index`, `cmd_rtype`, `cmd_kind` and `cmd_dir`, with `cmd_arg` carrying the argument. `cmd_valid` rises the cycle after the command write and stays high, payload unchanged, until `cmd_ready`.
- R2: A write to 0x04 replaces argument bits 15:0 and a write to 0x08 replaces bits 31:16. Each write leaves the other half unchanged.
- R3: Response byte k is `rsp_data[127-8k -: 8]`. Register i at 0x40+4i holds byte 2(7-i) in bits 15:8 and byte 2(7-i)+1 in bits 7:0. Register 7 therefore holds bytes 0 and 1.
- R4: Response type 0 sets status bit 7 when the request is accepted. Any other type that sees no response within (T+1)·2^TO_SHIFT cycles of waiting also sets bit 7 (T is the timeout register). The response registers are left unchanged in both cases.
- R5: Every command end — response taken, no-response type, or timeout — sets status bit 0.
- R6: For response type 1, status bit 14 is set if the 32-bit big-endian word in bytes 0..3 has any bit set in mask 0xFDF80000. Bit 3 is added to the mask when option register bit 13 is set.
- R7: For response type 3, status bit 12 is set when bit 31 of that word (bit 7 of byte 0) is clear.
- R8: For response type 6, status bit 14 is set if the 16-bit word in bytes 2..3 has any of bits 15:13 set. Bit 3 is added when option register bit 13 is set.
- R9: `irq` is high exactly when status AND interrupt-enable is nonzero. Writing status clears the bits written as 1. A bit set by an event in the same cycle stays set.
- R10: The timeout register is 8 bits wide. Writes of 0xFE or 0xFF are ignored and keep the previous value.
- R11: After reset, status, argument, interrupt enable, command word and response registers read zero, the timeout reads 0x40, and `cmd_valid`, `rsp_ready` and `irq` are low.
- R12: A command-word write while a command is in progress is ignored. The command word reads back unchanged.
- R13: `rsp_ready` is high only while a response is awaited, never while the request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Card accepts the request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 3 | Expected response type |
| cmd_kind | output | 2 | Command kind |
| cmd_dir | output | 1 | Data direction flag |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Engine awaits a response |
| rsp_data | input | 128 | Response bytes, byte 0 in the top bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the engine with TO_SHIFT = 2 and programs a timeout value of 3. The timeout window therefore shrinks to 16 waiting cycles. This makes it cheap to provoke an expiry, and to probe both before and after it, in the same run as many randomised commands. The default reset timeout of 0x40 stays observable at reset. It is then overridden, so the reserved-value writes can be seen to leave a known small value in place.

// File: rtl/cce_pkg.sv
package cce_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_ARGLO = 8'h04;
  localparam logic [7:0] OFS_ARGHI = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_IEN   = 8'h14;
  localparam logic [7:0] OFS_TMO   = 8'h18;
  localparam logic [7:0] OFS_OPT   = 8'h34;
  localparam logic [7:0] OFS_RSP0  = 8'h40;

  // response type codes
  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_STAT = 3'd1;
  localparam logic [2:0] RT_OCR  = 3'd3;
  localparam logic [2:0] RT_RCA  = 3'd6;

  // status bit positions
  localparam int ST_DONE    = 0;
  localparam int ST_NORSP   = 7;
  localparam int ST_OCRBUSY = 12;
  localparam int ST_CARDERR = 14;

  localparam logic [31:0] STAT_ERR_MASK = 32'hFDF8_0000;
  localparam logic [15:0] RCA_ERR_MASK  = 16'hE000;
  localparam int          AUTH_BIT      = 3;
  localparam int          OPT_AUTH_BIT  = 13;

  localparam int RSP_REGS = 8;
  localparam int HW       = 16;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cce_regs.sv
module cce_regs
  import cce_pkg::*;
#(
  parameter logic [7:0] TMO_RESET = 8'h40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_addr,
  input  logic [HW-1:0]                 bus_wdata,
  output logic [HW-1:0]                 bus_rdata,
  input  logic                          busy,
  input  logic [HW-1:0]                 status,
  input  logic [RSP_REGS-1:0][HW-1:0]   rsp_regs,
  output logic                          launch,
  output logic [5:0]                    f_index,
  output logic [2:0]                    f_rtype,
  output logic [1:0]                    f_kind,
  output logic                          f_dir,
  output logic [31:0]                   arg,
  output logic [HW-1:0]                 ien,
  output logic [7:0]                    tmo,
  output logic                          auth_en,
  output logic [HW-1:0]                 stat_clr
);
  logic [HW-1:0] cmd_word;
  logic          wr_cmd, wr_lo, wr_hi, wr_ien, wr_tmo, wr_opt, wr_stat;
  logic          tmo_reserved;

  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_lo   = bus_wr && (bus_addr == OFS_ARGLO);
  assign wr_hi   = bus_wr && (bus_addr == OFS_ARGHI);
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign wr_tmo  = bus_wr && (bus_addr == OFS_TMO);
  assign wr_opt  = bus_wr && (bus_addr == OFS_OPT);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);

  assign tmo_reserved = (bus_wdata[7:1] == 7'h7F);
  assign launch       = wr_cmd && !busy;
  assign stat_clr     = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      arg      <= '0;
      ien      <= '0;
      tmo      <= TMO_RESET;
      auth_en  <= 1'b0;
    end else begin
      if (launch) cmd_word <= bus_wdata;
      if (wr_lo)  arg[15:0]  <= bus_wdata;
      if (wr_hi)  arg[31:16] <= bus_wdata;
      if (wr_ien) ien <= bus_wdata;
      if (wr_tmo && !tmo_reserved) tmo <= bus_wdata[7:0];
      if (wr_opt) auth_en <= bus_wdata[OPT_AUTH_BIT];
    end
  end

  assign f_index = cmd_word[5:0];
  assign f_rtype = cmd_word[10:8];
  assign f_kind  = cmd_word[13:12];
  assign f_dir   = cmd_word[15];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CMD:   bus_rdata = cmd_word;
      OFS_ARGLO: bus_rdata = arg[15:0];
      OFS_ARGHI: bus_rdata = arg[31:16];
      OFS_STAT:  bus_rdata = status;
      OFS_IEN:   bus_rdata = ien;
      OFS_TMO:   bus_rdata = {8'h00, tmo};
      OFS_OPT:   bus_rdata = HW'(auth_en) << OPT_AUTH_BIT;
      default: begin
        if (bus_addr[7:5] == OFS_RSP0[7:5] && bus_addr[1:0] == 2'b00)
          bus_rdata = rsp_regs[bus_addr[4:2]];
      end
    endcase
  end

  AST_ARG_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(arg[31:16])); // R2
  AST_ARG_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(arg[15:0])); // R2
  AST_TMO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo && bus_wdata[7:1] == 7'h7F) |=> $stable(tmo)); // R10
  AST_CMD_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> $stable(cmd_word)); // R12
endmodule

// File: rtl/cce_seq.sv
module cce_seq
  import cce_pkg::*;
#(
  parameter int TO_SHIFT = 4,
  localparam int CNT_W   = 9 + TO_SHIFT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [2:0] rtype,
  input  logic [7:0] tmo,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic       rsp_ready,
  input  logic       rsp_valid,
  output logic       busy,
  output logic       ev_take,
  output logic       ev_norsp,
  output logic       ev_done
);
  seq_state_t       st;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] limit;
  logic             ev_skip, ev_expire;

  assign limit = CNT_W'({1'b0, tmo} + 9'd1) << TO_SHIFT;

  assign cmd_valid = (st == SQ_ISSUE);
  assign rsp_ready = (st == SQ_WAIT);
  assign busy      = (st != SQ_IDLE);
  assign ev_take   = rsp_ready && rsp_valid;
  assign ev_expire = rsp_ready && !rsp_valid && (wait_cnt >= limit - CNT_W'(1));
  assign ev_skip   = cmd_valid && cmd_ready && (rtype == RT_NONE);
  assign ev_norsp  = ev_skip || ev_expire;
  assign ev_done   = ev_norsp || ev_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      wait_cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (launch) st <= SQ_ISSUE;
        SQ_ISSUE: begin
          wait_cnt <= '0;
          if (cmd_ready) st <= (rtype == RT_NONE) ? SQ_IDLE : SQ_WAIT;
        end
        SQ_WAIT: begin
          if (ev_take || ev_expire) st <= SQ_IDLE;
          else wait_cnt <= wait_cnt + CNT_W'(1);
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(rtype))); // R1
  AST_RSP_READY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (busy && !cmd_valid)); // R13
  AST_VALID_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> cmd_valid); // R1
endmodule

// File: rtl/cce_rsp.sv
module cce_rsp
  import cce_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_take,
  input  logic                        ev_norsp,
  input  logic                        ev_done,
  input  logic [2:0]                  rtype,
  input  logic [127:0]                rsp_data,
  input  logic                        auth_en,
  input  logic [HW-1:0]               stat_clr,
  output logic [HW-1:0]               status,
  output logic [RSP_REGS-1:0][HW-1:0] rsp_regs
);
  logic [31:0]   head32;
  logic [15:0]   rca16;
  logic [31:0]   mask32;
  logic [15:0]   mask16;
  logic [HW-1:0] set_bits;

  assign head32 = rsp_data[127:96];
  assign rca16  = rsp_data[111:96];
  assign mask32 = STAT_ERR_MASK | (32'(auth_en) << AUTH_BIT);
  assign mask16 = RCA_ERR_MASK  | (16'(auth_en) << AUTH_BIT);

  always_comb begin
    set_bits = '0;
    if (ev_done)  set_bits[ST_DONE]  = 1'b1;
    if (ev_norsp) set_bits[ST_NORSP] = 1'b1;
    if (ev_take) begin
      if (rtype == RT_STAT && |(head32 & mask32)) set_bits[ST_CARDERR]  = 1'b1;
      if (rtype == RT_RCA  && |(rca16  & mask16)) set_bits[ST_CARDERR]  = 1'b1;
      if (rtype == RT_OCR  && !head32[31])        set_bits[ST_OCRBUSY]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~stat_clr) | set_bits;
  end

  for (genvar gi = 0; gi < RSP_REGS; gi++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rst_n)       rsp_regs[gi] <= '0;
      else if (ev_take) rsp_regs[gi] <= rsp_data[HW*gi +: HW];
    end
  end

  AST_NORSP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_NORSP]) |-> status[ST_DONE]); // R4
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> status[ST_DONE]); // R5
  AST_ERR_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_CARDERR]) |-> $past(ev_take)); // R6
  AST_RSP_KEPT_NORSP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_norsp && !ev_take) |=> $stable(rsp_regs)); // R4
endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import cce_pkg::*;
#(
  parameter int         TO_SHIFT  = 4,
  parameter logic [7:0] TMO_RESET = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [15:0]  bus_wdata,
  output logic [15:0]  bus_rdata,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic [5:0]   cmd_index,
  output logic [31:0]  cmd_arg,
  output logic [2:0]   cmd_rtype,
  output logic [1:0]   cmd_kind,
  output logic         cmd_dir,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [127:0] rsp_data,
  output logic         irq
);
  logic                        launch, busy, auth_en;
  logic                        ev_take, ev_norsp, ev_done;
  logic [HW-1:0]               ien, status, stat_clr;
  logic [7:0]                  tmo;
  logic [RSP_REGS-1:0][HW-1:0] rsp_regs;

  cce_regs #(.TMO_RESET(TMO_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .status(status), .rsp_regs(rsp_regs), .launch(launch),
    .f_index(cmd_index), .f_rtype(cmd_rtype), .f_kind(cmd_kind),
    .f_dir(cmd_dir), .arg(cmd_arg), .ien(ien), .tmo(tmo),
    .auth_en(auth_en), .stat_clr(stat_clr)
  );

  cce_seq #(.TO_SHIFT(TO_SHIFT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .rtype(cmd_rtype),
    .tmo(tmo), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .busy(busy),
    .ev_take(ev_take), .ev_norsp(ev_norsp), .ev_done(ev_done)
  );

  cce_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .ev_take(ev_take), .ev_norsp(ev_norsp),
    .ev_done(ev_done), .rtype(cmd_rtype), .rsp_data(rsp_data),
    .auth_en(auth_en), .stat_clr(stat_clr), .status(status),
    .rsp_regs(rsp_regs)
  );

  assign irq = |(status & ien);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R9
  AST_ARG_STABLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !bus_wr) |=> $stable(cmd_arg)); // R1
endmodule

// File: tb/test_card_cmd_engine.sv
module test_card_cmd_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic [15:0]  bus_rdata;
  logic         cmd_valid, cmd_ready = 1'b0;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic [2:0]   cmd_rtype;
  logic [1:0]   cmd_kind;
  logic         cmd_dir;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [127:0] rsp_data = '0;
  logic         irq;

  localparam int TOSH = 2;
  localparam int TMO  = 3;
  localparam int LIM  = (TMO + 1) << TOSH;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit auth = 0;
  logic [15:0] ien_val = '0;
  logic [15:0] shadow [8];

  always #5 clk = ~clk;

  card_cmd_engine #(.TO_SHIFT(TOSH)) i_card_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_rtype(cmd_rtype), .cmd_kind(cmd_kind), .cmd_dir(cmd_dir),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_status(input logic [2:0] rt, input bit answered,
                                             input logic [127:0] data, input bit au);
    logic [15:0] s;
    logic [31:0] m32;
    logic [15:0] m16;
    s = 16'h0001;
    m32 = 32'hFDF8_0000 | (au ? 32'h8 : 32'h0);
    m16 = 16'hE000 | (au ? 16'h8 : 16'h0);
    if (!answered) s |= 16'h0080;
    else begin
      if (rt == 3'd1 && (data[127:96] & m32) != 0) s |= 16'h4000;
      if (rt == 3'd6 && (data[111:96] & m16) != 0) s |= 16'h4000;
      if (rt == 3'd3 && !data[127]) s |= 16'h1000;
    end
    return s;
  endfunction

  task automatic run_cmd(input logic [5:0] idx, input logic [2:0] rt,
                         input logic [1:0] kind, input bit dir,
                         input logic [31:0] arg, input bit respond,
                         input int dly, input logic [127:0] data, input bit poke);
    logic [15:0] word, rd;
    logic [15:0] es;
    bit answered;
    word = {dir, 1'b0, kind, 1'b0, rt, 2'b00, idx};
    bus_write(8'h10, 16'hFFFF);
    bus_write(8'h04, arg[15:0]);
    bus_write(8'h08, arg[31:16]);
    bus_write(8'h00, word);
    chk(cmd_valid && cmd_index == idx && cmd_rtype == rt && cmd_kind == kind &&
        cmd_dir == dir && cmd_arg == arg, "R1 request fields",
        {cmd_valid, cmd_dir, cmd_kind, cmd_rtype, cmd_index, cmd_arg},
        {1'b1, dir, kind, rt, idx, arg});
    chk(!rsp_ready, "R13 no rsp_ready while request pending", rsp_ready, 0);
    for (int k = 0; k < dly; k++) @(negedge clk);
    chk(cmd_valid && cmd_arg == arg, "R1 request held until ready", cmd_valid, 1);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    answered = (rt != 3'd0) && respond;
    if (rt != 3'd0) begin
      if (poke) begin
        bus_write(8'h00, 16'h003F);
        bus_read(8'h00, rd);
        chk(rd == word, "R12 command write while busy ignored", rd, word);
      end
      if (respond) begin
        for (int k = 0; k < dly; k++) @(negedge clk);
        chk(rsp_ready, "R13 rsp_ready while waiting", rsp_ready, 1);
        rsp_valid = 1'b1; rsp_data = data;
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int r = 0; r < 8; r++) shadow[r] = data[16*r +: 16];
      end else begin
        for (int k = 0; k < LIM / 2 - 4; k++) @(negedge clk);
        bus_read(8'h10, rd);
        chk(rd[0] == 1'b0, "R4 no timeout before window", rd, 0);
        for (int k = 0; k < LIM + 2; k++) @(negedge clk);
      end
    end
    es = exp_status(rt, answered, data, auth);
    bus_read(8'h10, rd);
    chk(rd == es, answered ? "R5 R6 R7 R8 status after response" :
                             "R4 R5 status after no response", rd, es);
    for (int r = 0; r < 8; r++) begin
      bus_read(8'h40 + 8'(4 * r), rd);
      chk(rd == shadow[r], "R3 response register", rd, shadow[r]);
    end
    chk(irq == |(es & ien_val), "R9 irq level", irq, |(es & ien_val));
  endtask

  initial begin
    logic [15:0] rd;
    logic [127:0] d;
    logic [2:0] rt;
    void'($urandom(32'h5EED));
    for (int r = 0; r < 8; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    bus_read(8'h10, rd); chk(rd == 0, "R11 status reset", rd, 0);
    bus_read(8'h04, rd); chk(rd == 0, "R11 arg low reset", rd, 0);
    bus_read(8'h08, rd); chk(rd == 0, "R11 arg high reset", rd, 0);
    bus_read(8'h18, rd); chk(rd == 16'h40, "R11 timeout reset", rd, 16'h40);
    bus_read(8'h5C, rd); chk(rd == 0, "R11 response reset", rd, 0);
    chk(!cmd_valid && !rsp_ready && !irq, "R11 outputs low", {cmd_valid, rsp_ready, irq}, 0);
    // R2 argument halves
    bus_write(8'h04, 16'h1234);
    bus_write(8'h08, 16'hABCD);
    bus_write(8'h04, 16'h5678);
    bus_read(8'h08, rd); chk(rd == 16'hABCD, "R2 high half kept", rd, 16'hABCD);
    bus_read(8'h04, rd); chk(rd == 16'h5678, "R2 low half replaced", rd, 16'h5678);
    // R10 timeout reserved values
    bus_write(8'h18, 16'h0005);
    bus_write(8'h18, 16'h00FE);
    bus_read(8'h18, rd); chk(rd == 16'h5, "R10 0xFE ignored", rd, 5);
    bus_write(8'h18, 16'h00FF);
    bus_read(8'h18, rd); chk(rd == 16'h5, "R10 0xFF ignored", rd, 5);
    bus_write(8'h18, 16'h00FD);
    bus_read(8'h18, rd); chk(rd == 16'hFD, "R10 0xFD accepted", rd, 16'hFD);
    bus_write(8'h18, 16'(TMO));
    // directed corners
    run_cmd(6'd0, 3'd0, 2'd0, 1'b0, 32'h0, 1'b1, 0, '0, 1'b0);          // R4 no response type
    run_cmd(6'd17, 3'd1, 2'd1, 1'b1, 32'hDEAD_BEEF, 1'b0, 2, '0, 1'b1); // R4 timeout, R12
    run_cmd(6'd2, 3'd2, 2'd0, 1'b0, 32'h0102_0304, 1'b1, 1,
            128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 1'b1);        // R3 ordering
    run_cmd(6'd41, 3'd3, 2'd0, 1'b0, 32'h00FF_8000, 1'b1, 0,
            {32'h00FF_8000, 96'h0}, 1'b0);                               // R7 busy
    run_cmd(6'd41, 3'd3, 2'd0, 1'b0, 32'h00FF_8000, 1'b1, 0,
            {32'h80FF_8000, 96'h0}, 1'b0);                               // R7 ready
    run_cmd(6'd13, 3'd1, 2'd0, 1'b0, 32'h1, 1'b1, 0, {32'h0000_0008, 96'h0}, 1'b0); // R6 auth off
    bus_write(8'h34, 16'h2000); auth = 1;
    run_cmd(6'd13, 3'd1, 2'd0, 1'b0, 32'h1, 1'b1, 0, {32'h0000_0008, 96'h0}, 1'b0); // R6 auth on
    run_cmd(6'd3, 3'd6, 2'd0, 1'b0, 32'h0, 1'b1, 0, {32'h1234_2000, 96'h0}, 1'b0);  // R8
    // R9 interrupt and write-one-to-clear
    ien_val = 16'h0001; bus_write(8'h14, ien_val);
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq raised by enabled bit", irq, 1);
    bus_write(8'h10, 16'h0001);
    bus_read(8'h10, rd);
    chk(rd == 16'h2000 * 0 + (exp_status(3'd6, 1, {32'h1234_2000, 96'h0}, 1) & 16'hFFFE),
        "R9 write one clears only that bit", rd, 16'h4000);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    // random mix
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 6)
        0: rt = 3'd0; 1: rt = 3'd1; 2: rt = 3'd2;
        3: rt = 3'd3; 4: rt = 3'd6; default: rt = 3'd5;
      endcase
      d = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 2) d[127:96] &= 32'h0207_FFF7;
      if ($urandom % 4 == 0) begin
        auth = ~auth;
        bus_write(8'h34, auth ? 16'h2000 : 16'h0000);
      end
      ien_val = 16'($urandom);
      bus_write(8'h14, ien_val);
      run_cmd(6'($urandom), rt, 2'($urandom), 1'($urandom), $urandom,
              ($urandom % 8) != 0, int'($urandom % 4), d, 1'b0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, run hung");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule